// File: doc/BRIEF.md
# RISC Integer ALU with Shifts

This block is the integer execution unit of a load/store RISC pipeline. It is purely combinational. It takes two register operands, a 16-bit instruction constant, a 5-bit constant shift count and a 4-bit operation code. From these it produces a 32-bit result and a flag that is high when that result is zero. Under a single operation code space it provides wrapping arithmetic, the four register logic operations, signed and unsigned less-than compares, logic operations with a zero-extended constant, placement of a constant into the upper half-word, and zero- or sign-filling shifts.

A core decoder maps each instruction onto one operation code. It routes the first source register to `src_a`, the second source register to `src_b`, and the constant fields to `imm` and `shamt`. Shifts act on `src_b`, which is the second register field. Immediate-logic operations combine `src_a` with the constant. The result is valid in the same cycle that the inputs settle. Bitwise NOT needs no code of its own: NOR with `src_b` = 0 produces it.

Top module: `risc_alu`

## Requirements
- R1: Operation code 0 gives `src_a + src_b` modulo 2^32. A carry out of bit 31 is discarded and raises no indication.
- R2: Operation code 1 gives `src_a - src_b` modulo 2^32, with no overflow indication.
- R3: Operation codes 2, 3, 4 and 5 give the bitwise AND, OR, XOR and NOR of `src_a` and `src_b`. NOR with `src_b` = 0 gives the one's complement of `src_a`.
- R4: Operation code 6 gives 1 when `src_a` is less than `src_b` as two's-complement numbers, and 0 otherwise. The 0 case includes equal operands.
- R5: Operation code 7 gives 1 when `src_a` is less than `src_b` as unsigned numbers, and 0 otherwise.
- R6: Operation codes 8, 9 and 10 give the AND, OR and XOR of `src_a` with `imm` zero-extended to 32 bits. AND therefore clears bits 31:16, while OR and XOR pass bits 31:16 of `src_a` through unchanged.
- R7: Operation code 11 gives `imm` in bits 31:16 and zeros in bits 15:0, and `src_a` has no effect. For example, 0x00ff gives 0x00ff0000.
- R8: Operation code 12 shifts `src_b` left by `shamt` positions and fills the vacated low bits with zeros. For example, 0xff000000 by 3 gives 0xf8000000.
- R9: Operation code 13 shifts `src_b` right by `shamt` positions and fills the vacated high bits with zeros. For example, 0xff000000 by 3 gives 0x1fe00000.
- R10: Operation code 14 shifts `src_b` right by `shamt` positions and fills the vacated high bits with copies of bit 31. For example, 0xff000000 by 3 gives 0xffe00000.
- R11: Operation code 15 is unassigned and gives a result of 0.
- R12: `zero` is 1 exactly when `result` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand; the value that shifts act on |
| imm | input | 16 | Instruction constant |
| shamt | input | 5 | Constant shift count |
| op | input | 4 | Operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |

## Verification
Every result and the zero flag are due in the same cycle as the stimulus, because no register sits between any input and either output. The driver applies each operand set just after a rising clock edge and queues the expected result at that time. The monitor compares the queued item with the outputs on the following falling edge, which is half a period later, once the combinational paths have settled and before the driver applies the next set.

// File: rtl/risc_alu.sv
module risc_alu #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src_a,
  input  logic [WIDTH-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  input  logic [SHW-1:0]   shamt,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] result,
  output logic             zero
);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_NOR  = 4'd5;
  localparam logic [3:0] OP_SLT  = 4'd6;
  localparam logic [3:0] OP_SLTU = 4'd7;
  localparam logic [3:0] OP_ANDI = 4'd8;
  localparam logic [3:0] OP_ORI  = 4'd9;
  localparam logic [3:0] OP_XORI = 4'd10;
  localparam logic [3:0] OP_LUI  = 4'd11;
  localparam logic [3:0] OP_SLL  = 4'd12;
  localparam logic [3:0] OP_SRL  = 4'd13;
  localparam logic [3:0] OP_SRA  = 4'd14;
  localparam int PADW = WIDTH - IMM_W;

  // shared adder: subtract and both compares invert src_b and carry in one
  logic             inv_b;
  logic [WIDTH:0]   sum_ext;
  logic             lt_signed, lt_unsigned;

  assign inv_b   = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign sum_ext = {1'b0, src_a} + {1'b0, src_b ^ {WIDTH{inv_b}}} + {{WIDTH{1'b0}}, inv_b};

  assign lt_unsigned = ~sum_ext[WIDTH];
  assign lt_signed   = (src_a[WIDTH-1] != src_b[WIDTH-1]) ? src_a[WIDTH-1] : sum_ext[WIDTH-1];

  // immediate forms
  logic [WIDTH-1:0] imm_zx, imm_hi;
  assign imm_zx = {{PADW{1'b0}}, imm};
  assign imm_hi = {imm, {PADW{1'b0}}};

  // single right-shifting barrel; left shifts use bit reversal around it
  logic             go_left, fill;
  logic [WIDTH-1:0] b_rev, sh_in, sh_out, sh_rev;
  logic [WIDTH-1:0] stage [0:SHW];

  assign go_left = (op == OP_SLL);
  assign fill    = (op == OP_SRA) & src_b[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign b_rev[i]  = src_b[WIDTH-1-i];
    assign sh_rev[i] = sh_out[WIDTH-1-i];
  end

  assign sh_in    = go_left ? b_rev : src_b;
  assign stage[0] = sh_in;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stage[k+1] = shamt[k] ? {{DIST{fill}}, stage[k][WIDTH-1:DIST]} : stage[k];
  end

  assign sh_out = stage[SHW];

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: result = sum_ext[WIDTH-1:0];
      OP_AND:         result = src_a & src_b;
      OP_OR:          result = src_a | src_b;
      OP_XOR:         result = src_a ^ src_b;
      OP_NOR:         result = ~(src_a | src_b);
      OP_SLT:         result = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU:        result = {{(WIDTH-1){1'b0}}, lt_unsigned};
      OP_ANDI:        result = src_a & imm_zx;
      OP_ORI:         result = src_a | imm_zx;
      OP_XORI:        result = src_a ^ imm_zx;
      OP_LUI:         result = imm_hi;
      OP_SLL:         result = sh_rev;
      OP_SRL, OP_SRA: result = sh_out;
      default:        result = '0;
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/risc_alu_chk.sv
module risc_alu_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16,
  localparam int SHW = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] src_a,
  input logic [WIDTH-1:0] src_b,
  input logic [IMM_W-1:0] imm,
  input logic [SHW-1:0]   shamt,
  input logic [3:0]       op,
  input logic [WIDTH-1:0] result,
  input logic             zero
);

  always_comb begin
    if (op == 4'd0) begin
      AST_ADD_WRAP: assert (result == src_a + src_b); // R1
    end
    if (op == 4'd1) begin
      AST_SUB_WRAP: assert (result == src_a - src_b); // R2
    end
    if (op == 4'd6) begin
      AST_SLT_SIGNED: assert (result == WIDTH'($signed(src_a) < $signed(src_b))); // R4
    end
    if (op == 4'd7) begin
      AST_SLT_UNSIGNED: assert (result == WIDTH'(src_a < src_b)); // R5
    end
    if (op == 4'd11) begin
      AST_UPPER_IMM: assert (result[IMM_W-1:0] == '0 && result[WIDTH-1:WIDTH-IMM_W] == imm); // R7
    end
    if (op == 4'd14) begin
      AST_SIGN_FILL: assert (result == WIDTH'($signed(src_b) >>> shamt)); // R10
    end
    if (op == 4'd15) begin
      AST_UNUSED_CODE: assert (result == '0); // R11
    end
    if (zero) begin
      AST_ZERO_FLAG: assert (result == '0); // R12
    end
  end

endmodule

bind risc_alu risc_alu_chk u_chk (
  .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
  .op(op), .result(result), .zero(zero)
);

// File: tb/sim_risc_alu.sv
`timescale 1ns/1ps
module sim_risc_alu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic [4:0]  shamt = '0;
  logic [3:0]  op = '0;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int fails  = 0;

  logic [31:0] q_res [$];
  logic        q_zero [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  risc_alu u0 (
    .src_a(src_a), .src_b(src_b), .imm(imm), .shamt(shamt),
    .op(op), .result(result), .zero(zero)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [15:0] k, input logic [4:0] s,
                                        input logic [3:0] o);
    case (o)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return a ^ b;
      4'd5:  return ~(a | b);
      4'd6:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd7:  return (a < b) ? 32'd1 : 32'd0;
      4'd8:  return a & {16'h0, k};
      4'd9:  return a | {16'h0, k};
      4'd10: return a ^ {16'h0, k};
      4'd11: return {k, 16'h0};
      4'd12: return b << s;
      4'd13: return b >> s;
      4'd14: return 32'($signed(b) >>> s);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8, 4'd9, 4'd10: return "R6";
      4'd11: return "R7";
      4'd12: return "R8";
      4'd13: return "R9";
      4'd14: return "R10";
      default: return "R11";
    endcase
  endfunction

  // driver: apply after a rising edge, queue the expectation
  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [15:0] k,
                       input logic [4:0] s, input logic [3:0] o,
                       input logic [31:0] exp_res, input string tag);
    @(posedge clk);
    #1;
    src_a = a; src_b = b; imm = k; shamt = s; op = o;
    q_res.push_back(exp_res);
    q_zero.push_back(exp_res == 32'h0);
    q_tag.push_back(tag);
  endtask

  task automatic drive_m(input logic [31:0] a, input logic [31:0] b, input logic [15:0] k,
                         input logic [4:0] s, input logic [3:0] o);
    drive(a, b, k, s, o, model(a, b, k, s, o), tag_of(o));
  endtask

  // monitor: results are combinational, compare on the falling edge
  always @(negedge clk) begin
    if (q_res.size() > 0) begin
      logic [31:0] er;
      logic        ez;
      string       t;
      er = q_res.pop_front();
      ez = q_zero.pop_front();
      t  = q_tag.pop_front();
      checks++;
      if (result !== er) begin
        fails++;
        $display("FAIL %s op=%0d result actual=%h expected=%h", t, op, result, er);
      end
      checks++;
      if (zero !== ez) begin
        fails++;
        $display("FAIL R12 (%s) zero actual=%b expected=%b", t, zero, ez);
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: all inputs zero -> add of zeros, zero flag high (R12)
    drive(32'h0, 32'h0, 16'h0, 5'd0, 4'd0, 32'h0, "R12");

    // R1 wrap
    drive(32'hffffffff, 32'h1, 16'h0, 5'd0, 4'd0, 32'h0, "R1");
    drive(32'h7fffffff, 32'h1, 16'h0, 5'd0, 4'd0, 32'h80000000, "R1");
    // R2 wrap
    drive(32'h0, 32'h1, 16'h0, 5'd0, 4'd1, 32'hffffffff, "R2");
    drive(32'h1234, 32'h1234, 16'h0, 5'd0, 4'd1, 32'h0, "R2");
    // R3 NOT via NOR with zero
    drive(32'h0f0f00ff, 32'h0, 16'h0, 5'd0, 4'd5, 32'hf0f0ff00, "R3");
    drive(32'hff00ff00, 32'h0ff00ff0, 16'h0, 5'd0, 4'd2, 32'h0f000f00, "R3");
    // R4 signed compare corners
    drive(32'h80000000, 32'h7fffffff, 16'h0, 5'd0, 4'd6, 32'h1, "R4");
    drive(32'h7fffffff, 32'h80000000, 16'h0, 5'd0, 4'd6, 32'h0, "R4");
    drive(32'hffffffff, 32'h0, 16'h0, 5'd0, 4'd6, 32'h1, "R4");
    drive(32'h5, 32'h5, 16'h0, 5'd0, 4'd6, 32'h0, "R4");
    drive(32'hfffffffe, 32'hffffffff, 16'h0, 5'd0, 4'd6, 32'h1, "R4");
    // R5 unsigned compare corners
    drive(32'h80000000, 32'h7fffffff, 16'h0, 5'd0, 4'd7, 32'h0, "R5");
    drive(32'hffffffff, 32'h0, 16'h0, 5'd0, 4'd7, 32'h0, "R5");
    drive(32'h0, 32'hffffffff, 16'h0, 5'd0, 4'd7, 32'h1, "R5");
    drive(32'h5, 32'h5, 16'h0, 5'd0, 4'd7, 32'h0, "R5");
    // R6 zero-extended immediates
    drive(32'hffffffff, 32'h0, 16'h8001, 5'd0, 4'd8, 32'h00008001, "R6");
    drive(32'hab000000, 32'h0, 16'hffff, 5'd0, 4'd9, 32'hab00ffff, "R6");
    drive(32'hab00ff00, 32'h0, 16'hffff, 5'd0, 4'd10, 32'hab0000ff, "R6");
    // R7 upper immediate, src_a ignored
    drive(32'h0, 32'h0, 16'h00ff, 5'd0, 4'd11, 32'h00ff0000, "R7");
    drive(32'hdeadbeef, 32'h0, 16'h00ff, 5'd0, 4'd11, 32'h00ff0000, "R7");
    // R8/R9/R10 shift examples and edges
    drive(32'h0, 32'hff000000, 16'h0, 5'd3, 4'd12, 32'hf8000000, "R8");
    drive(32'h0, 32'hff000000, 16'h0, 5'd3, 4'd13, 32'h1fe00000, "R9");
    drive(32'h0, 32'hff000000, 16'h0, 5'd3, 4'd14, 32'hffe00000, "R10");
    drive(32'h0, 32'h00000001, 16'h0, 5'd31, 4'd12, 32'h80000000, "R8");
    drive(32'h0, 32'h80000000, 16'h0, 5'd31, 4'd13, 32'h00000001, "R9");
    drive(32'h0, 32'h80000000, 16'h0, 5'd31, 4'd14, 32'hffffffff, "R10");
    drive(32'h0, 32'h7fffffff, 16'h0, 5'd31, 4'd14, 32'h00000000, "R10");
    drive(32'h0, 32'h9abcdef0, 16'h0, 5'd0, 4'd14, 32'h9abcdef0, "R10");
    // R11 unassigned code
    drive(32'hffffffff, 32'hffffffff, 16'hffff, 5'd7, 4'd15, 32'h0, "R11");

    // random sweep over every code
    for (int o = 0; o < 16; o++) begin
      for (int n = 0; n < 24; n++) begin
        drive_m($urandom(), $urandom(), 16'($urandom()), 5'($urandom()), 4'(o));
      end
    end

    wait (q_res.size() == 0);
    @(posedge clk);
    summary();
    $finish;
  end

endmodule